// File: doc/BRIEF.md
# Bit-Reversed Density Modulator for a One-Bit DAC

This block turns a 10-bit level into a one-bit pulse stream for a digital-to-analog output that is smoothed by an external RC filter. A plain PWM gathers all of its high clocks into one pulse per period. This modulator keeps the same number of high clocks per period but scatters them through the period. As a result, most of the ripple sits at high frequencies, where a simple filter removes it cheaply.

A free-running slot counter steps through every value of the period. Its bits are wired in reverse order to form a comparison key, so the counter's fastest bit carries the most weight. The stream is high in a slot when that key is below the active level. The level is taken in only at the period boundary. A separate one-cycle marker flags the first slot of each period.

A parameter can choose straight (unreversed) bit order instead. That gives ordinary single-pulse PWM, which is useful for comparing the two.

Top module: `dpwm_density_dac`

## Requirements
- R1: The period is 2^W = 1024 clocks, and the slot counter wraps at the end of each period. `period_mark` is high for exactly one cycle, in slot 0 of each period, and never twice in a row.
- R2: In reversed order, the stream is high in slot s exactly when the reversal of s is below the active level. The reversal maps slot bit i to key bit W-1-i, so slot bit 0 carries the weight 512.
- R3: In every complete period, the number of high slots equals the active level of that period.
- R4: The level is captured only in the last slot of a period, or while reset is held. A change in mid-period has no effect on the rest of that period.
- R5: A level of 0 gives a stream that stays low. A level of 1023 gives exactly one low slot per period, and that slot is slot 1023.
- R6: For a level 2^k, the high slots are evenly spaced 1024/2^k clocks apart, counted across the period wrap. A level of 768 gives the repeating pattern high, high, high, low.
- R7: While reset is held, both outputs are low. The first cycle after release is slot 0 of a period, and that period uses the level present during reset.
- R8: With straight order selected, the stream is high in slots 0 up to level-1 and low in the rest of the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_in | input | W (10) | Requested level, in high clocks per period |
| pwm_out | output | 1 | Registered one-bit modulated stream |
| period_mark | output | 1 | Registered marker, high in slot 0 of each period |

## Verification
The bound checker takes its reference level from `duty_in` two clocks before each marker. It therefore assumes that `duty_in` is a clean synchronous signal and that reset is held for at least two clocks. The testbench changes the level only on falling edges and holds reset for several cycles each time. The high-count and period-length properties are checked only from the second marker after reset onward. Mid-period level changes are made on purpose, to show that the checker and the stream both ignore them until the next boundary.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  // Bit order used to build the comparison key from the slot counter.
  typedef enum logic {
    ORDER_STRAIGHT = 1'b0,
    ORDER_REVERSED = 1'b1
  } order_e;

endpackage

// File: rtl/dpwm_slot_counter.sv
module dpwm_slot_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] slot,
  output logic         last_slot,
  output logic         first_slot
);

  localparam logic [W-1:0] SLOT_MAX = {W{1'b1}};

  // Free-running count; wraps naturally from SLOT_MAX to zero.
  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= slot + 1'b1;
  end

  assign last_slot  = (slot == SLOT_MAX);
  assign first_slot = (slot == '0);

endmodule

// File: rtl/dpwm_order_map.sv
module dpwm_order_map #(
  parameter int              W     = 10,
  parameter dpwm_pkg::order_e ORDER = dpwm_pkg::ORDER_REVERSED
) (
  input  logic [W-1:0] slot,
  output logic [W-1:0] key
);

  // Pure wiring: reversed order puts the fastest counter bit on the key MSB.
  generate
    if (ORDER == dpwm_pkg::ORDER_REVERSED) begin : g_rev
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign key[i] = slot[W-1-i];
      end
    end else begin : g_straight
      assign key = slot;
    end
  endgenerate

endmodule

// File: rtl/dpwm_compare.sv
module dpwm_compare #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] duty_in,
  input  logic         load,
  input  logic         first_slot,
  input  logic [W-1:0] key,
  output logic         pwm_q,
  output logic         mark_q
);

  logic [W-1:0] level_q;

  // Level is held for a whole period; captured at wrap or during reset.
  always_ff @(posedge clk) begin
    if (rst || load) level_q <= duty_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q  <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      pwm_q  <= (key < level_q);
      mark_q <= first_slot;
    end
  end

endmodule

// File: rtl/dpwm_density_dac.sv
module dpwm_density_dac #(
  parameter int               W     = 10,
  parameter dpwm_pkg::order_e ORDER = dpwm_pkg::ORDER_REVERSED
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] duty_in,
  output logic         pwm_out,
  output logic         period_mark
);

  logic [W-1:0] slot;
  logic [W-1:0] key;
  logic         last_slot;
  logic         first_slot;

  dpwm_slot_counter #(.W(W)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .slot       (slot),
    .last_slot  (last_slot),
    .first_slot (first_slot)
  );

  dpwm_order_map #(.W(W), .ORDER(ORDER)) u_map (
    .slot (slot),
    .key  (key)
  );

  dpwm_compare #(.W(W)) u_compare (
    .clk        (clk),
    .rst        (rst),
    .duty_in    (duty_in),
    .load       (last_slot),
    .first_slot (first_slot),
    .key        (key),
    .pwm_q      (pwm_out),
    .mark_q     (period_mark)
  );

endmodule

// File: rtl/dpwm_density_chk.sv
module dpwm_density_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] duty_in,
  input logic         pwm_out,
  input logic         period_mark
);

  localparam int          PERIOD  = 1 << W;
  localparam logic [W:0]  LEN_EXP = (W+1)'(PERIOD);

  logic [W-1:0] d1, d2, ref_level;
  logic [W:0]   len, hi_cnt;
  logic         primed;

  always_ff @(posedge clk) begin
    d1 <= duty_in;
    d2 <= d1;
    if (rst) begin
      len       <= '0;
      hi_cnt    <= '0;
      ref_level <= '0;
      primed    <= 1'b0;
    end else if (period_mark) begin
      len       <= (W+1)'(1);
      hi_cnt    <= {{W{1'b0}}, pwm_out};
      ref_level <= d2;
      primed    <= 1'b1;
    end else begin
      if (len != {(W+1){1'b1}}) len <= len + 1'b1;
      hi_cnt <= hi_cnt + {{W{1'b0}}, pwm_out};
    end
  end

  // R1
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    (period_mark && primed) |-> (len == LEN_EXP));

  // R1
  mark_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    period_mark |=> !period_mark);

  // R3
  high_count_chk: assert property (@(posedge clk) disable iff (rst)
    (period_mark && primed) |-> (hi_cnt == {1'b0, ref_level}));

  // R7
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pwm_out && !period_mark));

endmodule

bind dpwm_density_dac dpwm_density_chk #(.W(W)) u_dpwm_chk (
  .clk         (clk),
  .rst         (rst),
  .duty_in     (duty_in),
  .pwm_out     (pwm_out),
  .period_mark (period_mark)
);

// File: tb/test_dpwm_density_dac.sv
`timescale 1ns/1ps
module test_dpwm_density_dac;

  localparam int W      = 10;
  localparam int PERIOD = 1 << W;
  localparam int NV     = 20;

  // Stimulus level and expected spacing of high slots (0 = no spacing check).
  localparam int VEC_DUTY [NV] = '{0, 1, 2, 4, 8, 16, 32, 64, 128, 256,
                                   512, 768, 1023, 3, 5, 100, 341, 513, 682, 1000};
  localparam int VEC_GAP  [NV] = '{0, 1024, 512, 256, 128, 64, 32, 16, 8, 4,
                                   2, 0, 0, 0, 0, 0, 0, 0, 0, 0};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] duty_in = '0;
  logic         pwm_rev, mark_rev, pwm_lin, mark_lin;
  int           checks = 0;
  int           errors = 0;

  always #2 clk = ~clk;

  dpwm_density_dac #(.W(W), .ORDER(dpwm_pkg::ORDER_REVERSED)) i_dpwm_density_dac (
    .clk(clk), .rst(rst), .duty_in(duty_in),
    .pwm_out(pwm_rev), .period_mark(mark_rev));

  dpwm_density_dac #(.W(W), .ORDER(dpwm_pkg::ORDER_STRAIGHT)) i_dpwm_density_dac_lin (
    .clk(clk), .rst(rst), .duty_in(duty_in),
    .pwm_out(pwm_lin), .period_mark(mark_lin));

  function automatic int rev(input int v);
    int r = 0;
    for (int i = 0; i < W; i++) if (v[i]) r |= (1 << (W-1-i));
    return r;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Samples one full period starting at the current negedge (slot 0).
  task automatic measure(input int d, input int gap, input bit mid, input int mid_d);
    int hi_r = 0, hi_l = 0, bad_r = 0, bad_l = 0, bad_mark = 0;
    int first = -1, last = -1, bad_gap = 0, low_slot = -1, mark0 = 0;
    for (int s = 0; s < PERIOD; s++) begin
      if (s > 0) @(negedge clk);
      if (mid && s == PERIOD/2) duty_in = W'(mid_d);
      if (s == 0) mark0 = mark_rev;
      else if (mark_rev || mark_lin) bad_mark++;
      if (s == 0 && !mark_lin) bad_mark++;
      if (pwm_rev != (rev(s) < d)) bad_r++;
      if (pwm_lin != (s < d)) bad_l++;
      if (pwm_lin) hi_l++;
      if (pwm_rev) begin
        hi_r++;
        if (last >= 0 && gap > 0 && (s - last) != gap) bad_gap++;
        if (first < 0) first = s;
        last = s;
      end else begin
        low_slot = s;
      end
    end
    if (gap > 0 && first >= 0 && (first + PERIOD - last) != gap) bad_gap++;
    check("R1", $sformatf("marker at slot 0, level %0d", d), mark0, 1);
    check("R1", $sformatf("stray markers, level %0d", d), bad_mark, 0);
    check("R2", $sformatf("reversed pattern mismatches, level %0d", d), bad_r, 0);
    check("R3", $sformatf("high count, level %0d", d), hi_r, d);
    check("R8", $sformatf("straight pattern mismatches, level %0d", d), bad_l, 0);
    check("R8", $sformatf("straight high count, level %0d", d), hi_l, d);
    if (gap > 0) check("R6", $sformatf("uneven spacing, level %0d", d), bad_gap, 0);
    if (d == 0) check("R5", "zero level high slots", hi_r, 0);
    if (d == PERIOD-1) check("R5", "full-scale low slot index", low_slot, PERIOD-1);
    if (mid) check("R4", $sformatf("mid-period change to %0d leaked", mid_d), bad_r, 0);
  endtask

  task automatic wait_mark();
    @(negedge clk);
    while (!mark_rev) @(negedge clk);
  endtask

  task automatic run_period(input int d, input int gap, input bit mid, input int mid_d);
    wait_mark();
    duty_in = W'(d);
    wait_mark();
    measure(d, gap, mid, mid_d);
  endtask

  initial begin
    int quiet_bad;
    // R7: reset holds outputs low even with a level that would drive high
    duty_in = 10'd512;
    quiet_bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pwm_rev || mark_rev || pwm_lin || mark_lin) quiet_bad++;
    end
    check("R7", "outputs active in reset", quiet_bad, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R7", "marker on first cycle after release", mark_rev, 1);
    measure(512, 2, 1'b0, 0);

    // Table walk
    for (int v = 0; v < NV; v++) run_period(VEC_DUTY[v], VEC_GAP[v], 1'b0, 0);

    // R6: 3/4 scale pattern high, high, high, low at slots 0..3
    wait_mark();
    duty_in = 10'd768;
    wait_mark();
    begin
      int pat = 0;
      for (int s = 0; s < 4; s++) begin
        if (s > 0) @(negedge clk);
        pat = (pat << 1) | int'(pwm_rev);
      end
      check("R6", "3/4 scale first four slots (binary 1110)", pat, 14);
    end

    // R4: mid-period change is ignored until the boundary
    run_period(200, 0, 1'b1, 900);
    wait_mark();
    measure(900, 0, 1'b0, 0);
    run_period(1023, 0, 1'b1, 0);
    wait_mark();
    measure(0, 0, 1'b0, 0);

    // R7: reset in mid-period, new level taken from the reset window
    wait_mark();
    repeat (300) @(negedge clk);
    rst = 1'b1;
    duty_in = 10'd768;
    quiet_bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (pwm_rev || mark_rev || pwm_lin || mark_lin) quiet_bad++;
    end
    check("R7", "outputs active in mid-run reset", quiet_bad, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R7", "marker after mid-run release", mark_rev, 1);
    measure(768, 0, 1'b0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=no completion expected=completion within 190000 cycles");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule